// File: doc/BRIEF.md
# Windowed Watchdog Supervisor with Start-up Escalation

This block supervises a host controller through service writes that arrive on a small, already decoded register port. Each write carries two fields together: a 3-bit operating-mode code and a 4-bit period code. Because both fields travel in one access, every mode change is also a watchdog service, and it sets a known new period. The period counter advances only on a prescaled tick enable. A period code selects a tick count that is computed from a base parameter.

After any reset, the supervisor opens a start-up interval and waits for the first legal service. If the interval runs out, it issues a reset pulse and watches again. If the second interval also runs out, it stops resetting and latches a fail-safe state. Only the synchronous power-on reset input clears that state.

Once the host runs in normal mode, each service must land inside the second half of the current period. A service that is too early, a period that expires with no service, and a write with an undefined code all produce a reset pulse of fixed length. In the other legal modes the period acts as a plain timeout.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, `sys_rst` is 0, `fail_safe` is 0 and `op_mode` is 0.
- R2: If no legal service arrives within STARTUP_TICKS ticks after reset is released, a reset pulse starts on the edge of the STARTUP_TICKS-th tick.
- R3: If the start-up interval that follows such a pulse also expires with no legal service, `fail_safe` rises on that tick and no pulse is issued. `fail_safe` stays high, writes have no effect on any output, and only `rst` clears it.
- R4: A reset pulse holds `sys_rst` high for exactly RST_LEN cycles, starting the cycle after the offending edge. `op_mode` returns to 0. Writes made during the pulse are ignored, and start-up monitoring restarts when the pulse ends.
- R5: A legal write (mode code 0 to 5 and period code 0 to 9) made during start-up or run ends start-up. It loads the new period, restarts the count, and shows its mode code on `op_mode` from the next cycle.
- R6: A write whose period code is 10 to 15 causes a reset pulse immediately, whatever the state of the window.
- R7: A write whose mode code is 6 or 7 causes a reset pulse immediately.
- R8: In normal mode (mode code 1), a legal write that arrives while fewer than half of the current period's ticks have elapsed causes a reset pulse.
- R9: In normal mode, a legal write made from half the period up to and including the tick that completes it is accepted. It produces no pulse and starts a new period, whose length may differ, with a fresh count.
- R10: If a period completes with no write in the same cycle, a reset pulse starts on that completing tick. This holds in every legal mode.
- R11: In the legal modes other than 1, no early check is made: a legal write is accepted at any point in the period.
- R12: A successful service clears the start-up failure history, so the next start-up expiry gives a reset pulse rather than fail-safe.
- R13: The counters advance only on cycles where `tick` is 1. Period code n lasts PER_BASE·2^n ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset; the only way to leave fail-safe |
| tick | input | 1 | Prescaled count enable for the period and start-up counters |
| wr_en | input | 1 | One-cycle strobe of a decoded service write |
| wr_mode | input | 3 | Operating-mode code of the write (0..5 legal, 1 = normal/windowed) |
| wr_period | input | 4 | Period code of the write (0..9 legal) |
| sys_rst | output | 1 | Registered reset pulse to the host, RST_LEN cycles |
| fail_safe | output | 1 | Registered sticky fail-safe flag |
| op_mode | output | 3 | Registered mode code of the last accepted service |

## Verification
The bench places writes on exact tick counts around both edges of the window. It uses the last too-early count, the first accepted count and the period-completing tick, so an off-by-one in the half-period compare or a wrong priority between a write and expiry shows up as a missing or extra pulse in the scoreboard. It runs the start-up escalation twice, once straight from reset and once after a service that should clear the history. A design that counts failures across services would enter fail-safe too soon, and one that never counts them would keep pulsing. It holds the tick low for many cycles and then writes, and a design that counts clock cycles instead of ticks would miss the early pulse. The bench also checks that writes made in fail-safe leave all outputs unchanged.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int MODE_W      = 3;
  localparam int PER_W       = 4;
  localparam int NUM_MODES   = 6;
  localparam int NUM_PERIODS = 10;
  localparam logic [MODE_W-1:0] MODE_NORMAL  = 3'd1;
  localparam logic [MODE_W-1:0] MODE_STANDBY = 3'd0;

  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_RUN   = 2'd1,
    ST_PULSE = 2'd2,
    ST_SAFE  = 2'd3
  } wd_state_e;
endpackage

// File: rtl/wdog_code_check.sv
module wdog_code_check
  import wdog_pkg::*;
#(
  parameter int PER_BASE = 4,
  parameter int CNT_W    = 12
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [PER_W-1:0]  period,
  output logic              mode_ok,
  output logic              per_ok,
  output logic [CNT_W-1:0]  ticks
);
  logic [CNT_W-1:0] per_tbl [NUM_PERIODS];

  for (genvar i = 0; i < NUM_PERIODS; i++) begin : g_tbl
    assign per_tbl[i] = CNT_W'(PER_BASE << i);
  end

  assign mode_ok = (mode < MODE_W'(NUM_MODES));
  assign per_ok  = (period < PER_W'(NUM_PERIODS));
  assign ticks   = per_ok ? per_tbl[period] : '0;

  always_comb begin
    if (per_ok) assert (ticks >= CNT_W'(2)); // R13
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse,
  output logic last
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [CW-1:0] pcnt;

  assign last = pulse && (pcnt == CW'(LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      pcnt  <= '0;
    end else if (fire && !pulse) begin
      pulse <= 1'b1;
      pcnt  <= '0;
    end else if (pulse) begin
      if (last) pulse <= 1'b0;
      else      pcnt  <= pcnt + 1'b1;
    end
  end

  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pulse && !last) |=> pulse); // R4
  AST_PULSE_END: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse) |-> ($past(pcnt) == CW'(LEN - 1))); // R4
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wdog_pkg::*;
#(
  parameter int PER_BASE      = 4,
  parameter int STARTUP_TICKS = 64,
  parameter int RST_LEN       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic [PER_W-1:0]  wr_period,
  output logic              sys_rst,
  output logic              fail_safe,
  output logic [MODE_W-1:0] op_mode
);
  localparam int MAX_PER = PER_BASE << (NUM_PERIODS - 1);
  localparam int MAX_T   = (MAX_PER > STARTUP_TICKS) ? MAX_PER : STARTUP_TICKS;
  localparam int CNT_W   = $clog2(MAX_T + 1);

  wd_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q, limit_q, new_limit;
  logic [MODE_W-1:0] mode_q;
  logic              second_q, fs_q;
  logic              mode_ok, per_ok, pulse_last;
  logic              active, bad_wr, good_wr, early;
  logic              exp_run, exp_start, fire, to_safe;

  wdog_code_check #(.PER_BASE(PER_BASE), .CNT_W(CNT_W)) u_check (
    .mode(wr_mode), .period(wr_period),
    .mode_ok(mode_ok), .per_ok(per_ok), .ticks(new_limit)
  );

  wdog_pulse #(.LEN(RST_LEN)) u_pulse (
    .clk(clk), .rst(rst), .fire(fire), .pulse(sys_rst), .last(pulse_last)
  );

  always_comb begin
    active    = (state_q == ST_START) || (state_q == ST_RUN);
    bad_wr    = active && wr_en && !(mode_ok && per_ok);
    good_wr   = active && wr_en && mode_ok && per_ok;
    early     = (state_q == ST_RUN) && (mode_q == MODE_NORMAL) && (cnt_q < (limit_q >> 1));
    exp_run   = (state_q == ST_RUN) && tick && (cnt_q == limit_q - 1'b1);
    exp_start = (state_q == ST_START) && tick && (cnt_q == CNT_W'(STARTUP_TICKS - 1));
    fire      = bad_wr || (good_wr && early) || (!wr_en && exp_run)
                || (!wr_en && exp_start && !second_q);
    to_safe   = !wr_en && exp_start && second_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_START;
      cnt_q    <= '0;
      limit_q  <= '0;
      mode_q   <= MODE_STANDBY;
      second_q <= 1'b0;
      fs_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_START, ST_RUN: begin
          if (fire) begin
            state_q <= ST_PULSE;
            mode_q  <= MODE_STANDBY;
            cnt_q   <= '0;
            if (!wr_en && exp_start) second_q <= 1'b1;
          end else if (to_safe) begin
            state_q <= ST_SAFE;
            fs_q    <= 1'b1;
          end else if (good_wr) begin
            state_q  <= ST_RUN;
            cnt_q    <= '0;
            limit_q  <= new_limit;
            mode_q   <= wr_mode;
            second_q <= 1'b0;
          end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PULSE: begin
          if (pulse_last) begin
            state_q <= ST_START;
            cnt_q   <= '0;
          end
        end
        default: state_q <= ST_SAFE;
      endcase
    end
  end

  assign fail_safe = fs_q;
  assign op_mode   = mode_q;

  AST_FS_STICKY: assert property (@(posedge clk) disable iff (rst)
    fail_safe |=> fail_safe); // R3
  AST_FS_QUIET: assert property (@(posedge clk) disable iff (rst)
    fail_safe |-> !sys_rst); // R3
  AST_BAD_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (active && wr_en && wr_period >= PER_W'(NUM_PERIODS)) |=> sys_rst); // R6
  AST_BAD_MODE: assert property (@(posedge clk) disable iff (rst)
    (active && wr_en && wr_mode >= MODE_W'(NUM_MODES)) |=> sys_rst); // R7
  AST_EARLY_HIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && wr_en && mode_q == MODE_NORMAL && cnt_q < (limit_q >> 1)) |=> sys_rst); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN) |-> (cnt_q < limit_q)); // R10
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    op_mode < MODE_W'(NUM_MODES)); // R5
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && !tick && !wr_en) |=> $stable(cnt_q)); // R13
endmodule

// File: tb/sim_wdog_supervisor.sv
module sim_wdog_supervisor;
  localparam int CLK_P = 10;
  localparam int S     = 64;
  localparam int L     = 4;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b1, wr_en = 1'b0;
  logic [2:0] wr_mode = '0;
  logic [3:0] wr_period = '0;
  logic sys_rst, fail_safe;
  logic [2:0] op_mode;

  int cyc = 0, n_cmp = 0, n_bad = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  wdog_supervisor u0 (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_mode(wr_mode),
    .wr_period(wr_period), .sys_rst(sys_rst), .fail_safe(fail_safe), .op_mode(op_mode)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_pulse(int at, string req);
    exp_q.push_back(at);
    tag_q.push_back(req);
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // drive a write so the design samples it on edge e
  task automatic wr_at(int e, logic [2:0] m, logic [3:0] p);
    wait_to(e - 1);
    wr_en = 1'b1; wr_mode = m; wr_period = p;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // scoreboard monitor
  logic prev = 1'b0;
  int   len  = 0;
  always @(negedge clk) begin
    if (sys_rst && !prev) begin
      if (exp_q.size() == 0) check("R4 unexpected pulse", cyc, -1);
      else begin
        string t;
        t = tag_q.pop_front();
        check(t, cyc, exp_q.pop_front());
      end
      len = 1;
    end else if (sys_rst) len++;
    else if (prev) check("R4 pulse length", len, L);
    prev = sys_rst;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      check("watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int c0, w, w2, w3, r, r2, r3, r4, r5;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 sys_rst", sys_rst, 0);
    check("R1 fail_safe", fail_safe, 0);
    check("R1 op_mode", op_mode, 0);
    rst = 1'b0; c0 = cyc;
    @(negedge clk);
    check("R1 post-release sys_rst", sys_rst, 0);
    // R2 first start-up expiry, R3 second one
    r = c0 + S;
    expect_pulse(r, "R2 start-up timeout");
    wait_to(r + L + S - 1);
    check("R3 not yet fail-safe", fail_safe, 0);
    @(negedge clk);
    check("R3 fail-safe entered", fail_safe, 1);
    wr_at(cyc + 2, 3'd1, 4'd1);
    wait_to(cyc + 100);
    check("R3 write ignored op_mode", op_mode, 0);
    check("R3 fail-safe sticky", fail_safe, 1);
    check("R3 no pulse in fail-safe", sys_rst, 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 cleared by rst", fail_safe, 0);
    rst = 1'b0; c0 = cyc;

    // R5 service, R8 too early
    wr_at(c0 + 3, 3'd1, 4'd1); w = c0 + 3;
    check("R5 op_mode loaded", op_mode, 1);
    expect_pulse(w + 4, "R8 too early");
    wr_at(w + 4, 3'd1, 4'd1); r = w + 4;
    wait_to(r + 1);
    check("R4 op_mode cleared", op_mode, 0);

    // R4 write during pulse ignored, R9 window edges
    wr_at(r + 2, 3'd2, 4'd0);
    check("R4 write in pulse ignored", op_mode, 0);
    wr_at(r + L + 1, 3'd1, 4'd1); w = r + L + 1;
    wr_at(w + 5, 3'd1, 4'd0); w2 = w + 5;
    wr_at(w2 + 4, 3'd1, 4'd2); w3 = w2 + 4;
    check("R9 last-tick write accepted", op_mode, 1);
    // R10 too late with 16-tick period
    expect_pulse(w3 + 16, "R10 too late");
    r = w3 + 16;
    wait_to(r + L);

    // R6 bad period, R7 bad mode
    expect_pulse(r + L + 1, "R6 illegal period");
    wr_at(r + L + 1, 3'd1, 4'd10); r = r + L + 1;
    wr_at(r + L + 1, 3'd1, 4'd0); w = r + L + 1;
    expect_pulse(w + 3, "R7 illegal mode");
    wr_at(w + 3, 3'd7, 4'd0); r = w + 3;

    // R11 no early check outside normal mode
    wr_at(r + L + 1, 3'd3, 4'd2); w = r + L + 1;
    check("R11 op_mode", op_mode, 3);
    wr_at(w + 1, 3'd0, 4'd0); w2 = w + 1;
    check("R11 early write accepted", op_mode, 0);
    expect_pulse(w2 + 4, "R10 expiry in non-normal mode");
    r = w2 + 4;

    // R12 service clears failure history
    r2 = r + L + S;
    expect_pulse(r2, "R12 start-up timeout 1");
    wr_at(r2 + L + 10, 3'd0, 4'd0); w = r2 + L + 10;
    r3 = w + 4;
    expect_pulse(r3, "R12 expiry after service");
    r4 = r3 + L + S;
    expect_pulse(r4, "R12 start-up gives reset not fail-safe");
    wait_to(r4 + 1);
    check("R12 fail_safe low", fail_safe, 0);

    // R13 tick gating and period mapping
    wr_at(r4 + L + 1, 3'd1, 4'd0); w = r4 + L + 1;
    tick = 1'b0;
    wait_to(w + 50);
    check("R13 frozen count no pulse", sys_rst, 0);
    expect_pulse(w + 51, "R13 early with frozen count");
    wr_at(w + 51, 3'd1, 4'd0); r5 = w + 51;
    tick = 1'b1;
    wr_at(r5 + L + 1, 3'd0, 4'd3); w = r5 + L + 1;
    expect_pulse(w + 32, "R13 code 3 lasts 32 ticks");
    wait_to(w + 32 + L + 3);
    check("R4 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule